// File: doc/BRIEF.md
# TLB Invalidate Command Decoder

This block sits behind the system-control register write port of a processor core and turns writes aimed at the translation-buffer maintenance indices into invalidate commands for two separate TLBs, one for instruction fetch and one for data. A maintenance write carries no state. Nothing is stored for a later read. The write is converted into a one-cycle command pulse on the instruction side, the data side, or both, together with the page address and the address-space identifier (ASID) that the command applies to.

Four kinds of invalidation exist. Each TLB has its own pulse for each kind:
- flush everything;
- flush one page within one ASID;
- flush every entry of one ASID;
- flush one page under any ASID.

The index selects both the kind and the target TLBs. An inner-shareable index acts exactly like its unified local counterpart. The outputs are registered, so the command appears in the cycle after the write strobe.

Top module: `tlb_maint_dec`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every command pulse is low and the page address and ASID outputs are zero.
- R2: Indices 0 and 1 pulse invalidate-all on both TLBs. Index 2 pulses it on the instruction TLB only. Index 3 pulses it on the data TLB only.
- R3: Indices 4 and 5 pulse invalidate-by-page-and-ASID on both TLBs, index 6 on the instruction TLB only, and index 7 on the data TLB only. The page address output is write data bits 31:12 followed by twelve zero bits. The ASID output is write data bits 7:0.
- R4: Indices 8 and 9 pulse invalidate-by-ASID on both TLBs, index 10 on the instruction TLB only, and index 11 on the data TLB only. The ASID output is write data bits 7:0 and the page address output is zero.
- R5: Indices 12 and 13 pulse invalidate-by-page-any-ASID on both TLBs. The page address output is write data bits 31:12 followed by twelve zero bits, and the ASID output is zero.
- R6: A command pulse appears exactly one cycle after the clock edge that samples the write strobe. It lasts one cycle unless a further command is written in the next cycle.
- R7: In any cycle each TLB receives at most one kind of command. When both TLBs are targeted, they receive the same kind.
- R8: With the strobe low, or with an index of 14 or above, no pulse is produced and the page address and ASID outputs keep their previous values.
- R9: Bits 11:0 of the page address output are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the maintenance register port |
| wr_idx_i | input | IDX_W (5) | Register index of the write |
| wr_data_i | input | 32 | Write data carrying page address and ASID |
| itlb_all_o | output | 1 | Instruction TLB: invalidate everything |
| itlb_va_asid_o | output | 1 | Instruction TLB: invalidate page within ASID |
| itlb_asid_o | output | 1 | Instruction TLB: invalidate whole ASID |
| itlb_va_o | output | 1 | Instruction TLB: invalidate page under any ASID |
| dtlb_all_o | output | 1 | Data TLB: invalidate everything |
| dtlb_va_asid_o | output | 1 | Data TLB: invalidate page within ASID |
| dtlb_asid_o | output | 1 | Data TLB: invalidate whole ASID |
| dtlb_va_o | output | 1 | Data TLB: invalidate page under any ASID |
| page_addr_o | output | 32 | Page address of the current command |
| asid_o | output | 8 | ASID of the current command |

## Verification
Every index from 0 to 31 is written once with a marked data word. This separates the unified, inner-shareable, instruction-only and data-only variants, and it shows that the unused indices leave the outputs untouched. Writes issued back to back, and writes separated by idle cycles, tell a held pulse apart from a fresh one. A random mix of strobes, indices and data words then checks the field extraction. The data words have all-ones low bits and random ASIDs, which exposes a page address that leaks low bits and a field that the command kind should zero.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int unsigned N_TLB  = 2;
  localparam int unsigned TLB_I  = 0;
  localparam int unsigned TLB_D  = 1;

  // maintenance indices; grouping by four drives the decode below
  localparam int unsigned IX_ALL       = 0;
  localparam int unsigned IX_ALL_IS    = 1;
  localparam int unsigned IX_I_ALL     = 2;
  localparam int unsigned IX_D_ALL     = 3;
  localparam int unsigned IX_VA_ASID   = 4;
  localparam int unsigned IX_VA_ASID_IS= 5;
  localparam int unsigned IX_I_VA_ASID = 6;
  localparam int unsigned IX_D_VA_ASID = 7;
  localparam int unsigned IX_ASID      = 8;
  localparam int unsigned IX_ASID_IS   = 9;
  localparam int unsigned IX_I_ASID    = 10;
  localparam int unsigned IX_D_ASID    = 11;
  localparam int unsigned IX_VA_ANY    = 12;
  localparam int unsigned IX_VA_ANY_IS = 13;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ALL     = 3'd1,
    OP_VA_ASID = 3'd2,
    OP_ASID    = 3'd3,
    OP_VA_ANY  = 3'd4
  } tlbm_op_e;

  typedef struct packed {
    tlbm_op_e op;
    logic     to_i;
    logic     to_d;
  } tlbm_dec_t;
endpackage

// File: rtl/tlbm_index_decode.sv
module tlbm_index_decode
  import tlbm_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output tlbm_dec_t        dec_o
);
  tlbm_dec_t dec;

  always_comb begin
    dec = '{op: OP_NONE, to_i: 1'b0, to_d: 1'b0};
    case (idx_i)
      IDX_W'(IX_ALL), IDX_W'(IX_ALL_IS):             dec = '{OP_ALL,     1'b1, 1'b1};
      IDX_W'(IX_I_ALL):                              dec = '{OP_ALL,     1'b1, 1'b0};
      IDX_W'(IX_D_ALL):                              dec = '{OP_ALL,     1'b0, 1'b1};
      IDX_W'(IX_VA_ASID), IDX_W'(IX_VA_ASID_IS):     dec = '{OP_VA_ASID, 1'b1, 1'b1};
      IDX_W'(IX_I_VA_ASID):                          dec = '{OP_VA_ASID, 1'b1, 1'b0};
      IDX_W'(IX_D_VA_ASID):                          dec = '{OP_VA_ASID, 1'b0, 1'b1};
      IDX_W'(IX_ASID), IDX_W'(IX_ASID_IS):           dec = '{OP_ASID,    1'b1, 1'b1};
      IDX_W'(IX_I_ASID):                             dec = '{OP_ASID,    1'b1, 1'b0};
      IDX_W'(IX_D_ASID):                             dec = '{OP_ASID,    1'b0, 1'b1};
      IDX_W'(IX_VA_ANY), IDX_W'(IX_VA_ANY_IS):       dec = '{OP_VA_ANY,  1'b1, 1'b1};
      default:                                       dec = '{OP_NONE,    1'b0, 1'b0};
    endcase
    if (!en_i) dec = '{OP_NONE, 1'b0, 1'b0};
  end

  assign dec_o = dec;
endmodule

// File: rtl/tlbm_field_extract.sv
module tlbm_field_extract
  import tlbm_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned ASID_W   = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  tlbm_op_e          op_i,
  output logic [DATA_W-1:0] page_o,
  output logic [ASID_W-1:0] asid_o
);
  localparam int unsigned PAGE_W = DATA_W - PAGE_LSB;

  logic use_page, use_asid;

  assign use_page = (op_i == OP_VA_ASID) || (op_i == OP_VA_ANY);
  assign use_asid = (op_i == OP_VA_ASID) || (op_i == OP_ASID);

  // fields a command does not use are forced to zero
  assign page_o = use_page ? {data_i[DATA_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}}
                           : {PAGE_W'(0), {PAGE_LSB{1'b0}}};
  assign asid_o = use_asid ? data_i[ASID_W-1:0] : '0;
endmodule

// File: rtl/tlbm_cmd_reg.sv
module tlbm_cmd_reg
  import tlbm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tlbm_dec_t         dec_i,
  input  logic [DATA_W-1:0] page_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic [N_TLB-1:0]  all_o,
  output logic [N_TLB-1:0]  va_asid_o,
  output logic [N_TLB-1:0]  asid_cmd_o,
  output logic [N_TLB-1:0]  va_o,
  output logic [DATA_W-1:0] page_o,
  output logic [ASID_W-1:0] asid_o
);
  logic cmd_vld;
  assign cmd_vld = (dec_i.op != OP_NONE);

  for (genvar t = 0; t < N_TLB; t++) begin : g_tlb
    logic sel;
    assign sel = (t == TLB_I) ? dec_i.to_i : dec_i.to_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        all_o[t]      <= 1'b0;
        va_asid_o[t]  <= 1'b0;
        asid_cmd_o[t] <= 1'b0;
        va_o[t]       <= 1'b0;
      end else begin
        all_o[t]      <= sel && (dec_i.op == OP_ALL);
        va_asid_o[t]  <= sel && (dec_i.op == OP_VA_ASID);
        asid_cmd_o[t] <= sel && (dec_i.op == OP_ASID);
        va_o[t]       <= sel && (dec_i.op == OP_VA_ANY);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      asid_o <= '0;
    end else if (cmd_vld) begin
      page_o <= page_i;
      asid_o <= asid_i;
    end
  end
endmodule

// File: rtl/tlb_maint_dec.sv
module tlb_maint_dec
  import tlbm_pkg::*;
#(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned ASID_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              itlb_all_o,
  output logic              itlb_va_asid_o,
  output logic              itlb_asid_o,
  output logic              itlb_va_o,
  output logic              dtlb_all_o,
  output logic              dtlb_va_asid_o,
  output logic              dtlb_asid_o,
  output logic              dtlb_va_o,
  output logic [DATA_W-1:0] page_addr_o,
  output logic [ASID_W-1:0] asid_o
);
  tlbm_dec_t          dec;
  logic [DATA_W-1:0]  page_nxt;
  logic [ASID_W-1:0]  asid_nxt;
  logic [N_TLB-1:0]   all_q, va_asid_q, asid_q, va_q;

  tlbm_index_decode #(.IDX_W(IDX_W)) u_dec (
    .en_i  (wr_en_i),
    .idx_i (wr_idx_i),
    .dec_o (dec)
  );

  tlbm_field_extract #(.DATA_W(DATA_W), .PAGE_LSB(PAGE_LSB), .ASID_W(ASID_W)) u_fld (
    .data_i (wr_data_i),
    .op_i   (dec.op),
    .page_o (page_nxt),
    .asid_o (asid_nxt)
  );

  tlbm_cmd_reg #(.DATA_W(DATA_W), .ASID_W(ASID_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dec_i      (dec),
    .page_i     (page_nxt),
    .asid_i     (asid_nxt),
    .all_o      (all_q),
    .va_asid_o  (va_asid_q),
    .asid_cmd_o (asid_q),
    .va_o       (va_q),
    .page_o     (page_addr_o),
    .asid_o     (asid_o)
  );

  assign itlb_all_o     = all_q[TLB_I];
  assign itlb_va_asid_o = va_asid_q[TLB_I];
  assign itlb_asid_o    = asid_q[TLB_I];
  assign itlb_va_o      = va_q[TLB_I];
  assign dtlb_all_o     = all_q[TLB_D];
  assign dtlb_va_asid_o = va_asid_q[TLB_D];
  assign dtlb_asid_o    = asid_q[TLB_D];
  assign dtlb_va_o      = va_q[TLB_D];
endmodule

// File: rtl/tlb_maint_dec_chk.sv
module tlb_maint_dec_chk #(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned ASID_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              itlb_all_o,
  input logic              itlb_va_asid_o,
  input logic              itlb_asid_o,
  input logic              itlb_va_o,
  input logic              dtlb_all_o,
  input logic              dtlb_va_asid_o,
  input logic              dtlb_asid_o,
  input logic              dtlb_va_o,
  input logic [DATA_W-1:0] page_addr_o,
  input logic [ASID_W-1:0] asid_o
);
  logic [3:0] i_cmd, d_cmd;
  logic       any_cmd;
  assign i_cmd   = {itlb_all_o, itlb_va_asid_o, itlb_asid_o, itlb_va_o};
  assign d_cmd   = {dtlb_all_o, dtlb_va_asid_o, dtlb_asid_o, dtlb_va_o};
  assign any_cmd = |{i_cmd, d_cmd};

  assert_one_kind_i_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(i_cmd));
  assert_one_kind_d_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(d_cmd));
  assert_same_kind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|i_cmd) && (|d_cmd)) |-> (i_cmd == d_cmd));
  assert_pulse_after_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cmd |-> $past(wr_en_i));
  assert_idle_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> (!any_cmd && $stable(page_addr_o) && $stable(asid_o)));
  assert_page_any_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (itlb_va_o || dtlb_va_o) |->
      (page_addr_o[DATA_W-1:PAGE_LSB] == $past(wr_data_i[DATA_W-1:PAGE_LSB]) && asid_o == '0));
  assert_asid_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (itlb_asid_o || dtlb_asid_o) |->
      (asid_o == $past(wr_data_i[ASID_W-1:0]) && page_addr_o == '0));
  assert_page_asid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (itlb_va_asid_o || dtlb_va_asid_o) |->
      (asid_o == $past(wr_data_i[ASID_W-1:0]) &&
       page_addr_o[DATA_W-1:PAGE_LSB] == $past(wr_data_i[DATA_W-1:PAGE_LSB])));
  assert_page_low_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_cmd) |-> (page_addr_o[PAGE_LSB-1:0] == '0));
endmodule

bind tlb_maint_dec tlb_maint_dec_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .PAGE_LSB(PAGE_LSB), .ASID_W(ASID_W)
) u_chk (.*);

// File: tb/tlb_maint_dec_tb.sv
module tlb_maint_dec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic i_all, i_va_asid, i_asid, i_va, d_all, d_va_asid, d_asid, d_va;
  logic [31:0] page;
  logic [7:0]  asid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_page = '0;
  logic [7:0]  exp_asid = '0;

  always #4 clk = ~clk;

  tlb_maint_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .itlb_all_o(i_all), .itlb_va_asid_o(i_va_asid), .itlb_asid_o(i_asid), .itlb_va_o(i_va),
    .dtlb_all_o(d_all), .dtlb_va_asid_o(d_va_asid), .dtlb_asid_o(d_asid), .dtlb_va_o(d_va),
    .page_addr_o(page), .asid_o(asid)
  );

  // expected pulse vector {i_all,i_va_asid,i_asid,i_va,d_all,d_va_asid,d_asid,d_va}
  function automatic logic [7:0] exp_cmd(input logic en, input logic [4:0] idx);
    int grp = idx / 4;
    int sub = idx % 4;
    logic ti, td;
    logic [3:0] kind;
    if (!en || idx > 13) return 8'h00;
    ti = (sub != 3);
    td = (sub != 2);
    kind = 4'b1000 >> grp;
    return {ti ? kind : 4'h0, td ? kind : 4'h0};
  endfunction

  function automatic string req_of(input logic en, input logic [4:0] idx);
    if (!en || idx > 13) return "R8";
    case (idx / 4)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at a negedge, check at the next negedge (one register stage)
  task automatic step(input logic en, input logic [4:0] idx, input logic [31:0] data);
    logic [7:0] ec;
    string rq;
    wr_en = en; wr_idx = idx; wr_data = data;
    ec = exp_cmd(en, idx);
    rq = req_of(en, idx);
    if (ec != 8'h00) begin
      exp_page = (idx >= 4 && idx <= 7) || idx >= 12 ? {data[31:12], 12'h000} : 32'h0;
      exp_asid = (idx >= 4 && idx <= 11) ? data[7:0] : 8'h00;
    end
    @(negedge clk);
    check(rq, "pulses (R6/R7)", 64'({i_all, i_va_asid, i_asid, i_va, d_all, d_va_asid, d_asid, d_va}), 64'(ec));
    check(rq, "page", 64'(page), 64'(exp_page));
    check(rq, "asid", 64'(asid), 64'(exp_asid));
    check("R9", "page low bits", 64'(page[11:0]), 64'h0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    #20;
    check("R1", "reset pulses", 64'({i_all, i_va_asid, i_asid, i_va, d_all, d_va_asid, d_asid, d_va}), 64'h0);
    check("R1", "reset page/asid", 64'({page, asid}), 64'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset outputs", 64'({i_all, d_all, page, asid}), 64'h0);

    // every index, isolated by an idle cycle (R6 pulse ends)
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 5'(i), 32'hA5C3_9FFF ^ (32'(i) << 13) ^ 32'(i));
      step(1'b0, 5'(i), 32'hFFFF_FFFF);
    end
    // back-to-back: same kind repeated, then alternating kinds (R6)
    step(1'b1, 5'd4, 32'h1234_5FAB);
    step(1'b1, 5'd4, 32'h8765_4F12);
    step(1'b1, 5'd10, 32'hDEAD_BE77);
    step(1'b1, 5'd12, 32'hCAFE_F0FF);
    step(1'b1, 5'd15, 32'h0000_0000);
    step(1'b1, 5'd3, 32'h0);
    step(1'b0, 5'd0, 32'h0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] d;
      d = $urandom();
      if ($urandom_range(3) == 0) d[11:0] = 12'hFFF;
      step($urandom_range(3) != 0, 5'($urandom_range(31)), d);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule